// File: doc/BRIEF.md
# Double-Buffered Crosspoint Configuration Controller

This block holds the routing state of a 32-output, 33-input switch and performs the bit-level selection for every output. The 33 inputs are 32 data inputs plus one shared "advertise" line. A host programs it over a plain memory-mapped write port. That port has an active-low select, a 10-bit address, a 16-bit data word and an active-low load strobe. The address carries the source (an input index and an advertise-override flag). The data word names the destination outputs.

Every output owns a 6-bit routing entry held twice. Ordinary writes fill a staging bank. A low pulse on the commit input then moves the whole staging bank into the live bank, so that any number of outputs switch on the same edge. Broadcast writes skip staging and reach every output at once. When the transparent-mode input is held high, unicast and multicast writes also reach the live bank at once. All state changes happen on the rising clock edge. The output bits are a combinational function of the live bank, the data inputs and the advertise line.

Top module: `xbar_cfg`

## Requirements
- R1: After reset, every output k has a staging entry and a live entry that select data input k, with the advertise flag at 0.
- R2: Output bit k equals adv_in when bit 5 of its live entry is 1. Otherwise it equals din[e], where e is bits [4:0] of its live entry.
- R3: A unicast write uses addr[9]=0 and addr[8]=0. It stores the entry {addr[5], addr[4:0]} into the staging entry of output wdata[4:0] only. With transparent mode off, the live bank is unchanged.
- R4: A multicast write uses addr[9]=0 and addr[8]=1. It stores the entry into the staging entry of every output in one half whose bit in wdata[15:0] is 1. addr[7]=0 selects outputs 0..15, with wdata bit j mapped to output j. addr[7]=1 selects outputs 16..31, with wdata bit j mapped to output 16+j.
- R5: A broadcast write has addr[9]=1. On that same edge it stores the entry into both the staging and the live entry of all 32 outputs, without any commit.
- R6: When addr[5] is 1 in a write, every targeted output routes adv_in and addr[4:0] has no effect on its output.
- R7: On an edge where commit_n is low, every live entry not being written directly takes the value its staging entry had before that edge.
- R8: A write happens only on an edge where sel_n and wr_n are both low. Otherwise both banks keep their values.
- R9: transp is registered on each edge. While the registered value is 1, unicast and multicast writes update the live entries of their targets on the same edge as the staging entries.
- R10: On an edge with both a direct write (broadcast or transparent) and commit_n low, the targeted outputs take the written entry. All other outputs take their staging entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low load strobe |
| addr | input | 10 | Write address: mode, half, advertise flag and input index |
| wdata | input | 16 | Output index (unicast) or half mask (multicast) |
| commit_n | input | 1 | Active-low copy of the staging bank into the live bank |
| transp | input | 1 | Transparent-mode request, registered |
| din | input | 32 | Data inputs |
| adv_in | input | 1 | Advertise input |
| dout | output | 32 | Switched outputs |

## Verification
Several properties are checked on every cycle:
- the live bank holds still when there is no write and no commit;
- a non-transparent unicast or multicast write leaves the live bank untouched;
- a plain commit copies the staging bank exactly;
- a broadcast fills the live bank with one entry;
- any output whose live advertise flag is set follows adv_in.

Other behaviours depend on the values chosen, so only the bench scenarios show them: the index and half decoding of unicast and multicast writes, the timing of transparent mode, and the mixing of a commit with a direct write on one edge. The bench probes the outputs with several data patterns after each operation.

// File: rtl/xbar_cfg.sv
module xbar_cfg #(
  parameter int NPORT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic               wr_n,
  input  logic [9:0]         addr,
  input  logic [NPORT/2-1:0] wdata,
  input  logic               commit_n,
  input  logic               transp,
  input  logic [NPORT-1:0]   din,
  input  logic               adv_in,
  output logic [NPORT-1:0]   dout
);
  localparam int IW   = $clog2(NPORT);
  localparam int EW   = IW + 1;
  localparam int HALF = NPORT / 2;

  logic [EW-1:0]       pend [NPORT];
  logic [EW-1:0]       act  [NPORT];
  logic [NPORT*EW-1:0] pend_flat, act_flat;
  logic [NPORT-1:0]    tgt;
  logic                transp_q;

  wire           wr_fire = !sel_n && !wr_n;
  wire           is_bc   = addr[9];
  wire           is_mc   = !addr[9] && addr[8];
  wire [EW-1:0]  new_ent = {addr[IW], addr[IW-1:0]};
  wire           direct  = wr_fire && (is_bc || transp_q);

  always_comb begin
    tgt = '0;
    if (is_bc)
      tgt = '1;
    else if (is_mc) begin
      if (addr[7]) tgt[NPORT-1:HALF] = wdata;
      else         tgt[HALF-1:0]     = wdata;
    end else
      tgt[wdata[IW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) transp_q <= 1'b0;
    else        transp_q <= transp;

  for (genvar i = 0; i < NPORT; i++) begin : g_out
    localparam logic [EW-1:0] RST_ENT = EW'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= RST_ENT;
        act[i]  <= RST_ENT;
      end else begin
        if (wr_fire && tgt[i]) pend[i] <= new_ent;
        if (direct && tgt[i])  act[i]  <= new_ent;
        else if (!commit_n)    act[i]  <= pend[i];
      end
    end

    assign dout[i] = act[i][IW] ? adv_in : din[act[i][IW-1:0]];
    assign pend_flat[i*EW +: EW] = pend[i];
    assign act_flat[i*EW +: EW]  = act[i];
  end
endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
  parameter int NPORT = 32
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                sel_n,
  input logic                                wr_n,
  input logic                                commit_n,
  input logic                                bc,
  input logic [$clog2(NPORT):0]              ent,
  input logic                                transp_q,
  input logic                                adv_in,
  input logic [NPORT-1:0]                    dout,
  input logic [NPORT*($clog2(NPORT)+1)-1:0]  pend_flat,
  input logic [NPORT*($clog2(NPORT)+1)-1:0]  act_flat
);
  localparam int IW = $clog2(NPORT);
  localparam int EW = IW + 1;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || wr_n) && commit_n |=> $stable(act_flat)); // R8

  AST_STAGED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n && !wr_n && !bc && !transp_q && commit_n |=> $stable(act_flat)); // R3 R4

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_n && (sel_n || wr_n) |=> act_flat == $past(pend_flat)); // R7

  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n && !wr_n && bc |=> act_flat == {NPORT{$past(ent)}}); // R5

  for (genvar i = 0; i < NPORT; i++) begin : g_adv
    AST_ADV_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      act_flat[i*EW+IW] |-> dout[i] == adv_in); // R6
  end
endmodule

bind xbar_cfg xbar_cfg_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .commit_n(commit_n),
  .bc(addr[9]), .ent({addr[IW], addr[IW-1:0]}), .transp_q(transp_q),
  .adv_in(adv_in), .dout(dout), .pend_flat(pend_flat), .act_flat(act_flat)
);

// File: tb/xbar_cfg_bench.sv
module xbar_cfg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, wr_n = 1'b1, commit_n = 1'b1, transp = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] din = '0;
  logic        adv_in = 1'b0;
  logic [31:0] dout;

  xbar_cfg u_xbar_cfg (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] d;
    logic        a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  logic [5:0]  mp [32];
  logic [5:0]  ma [32];
  bit          tm = 1'b0;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] model_out(logic [31:0] d, logic a);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = ma[i][5] ? a : d[ma[i][4:0]];
    return r;
  endfunction

  function automatic void model_step(bit fire, logic [9:0] a, logic [15:0] d, bit cm);
    logic [31:0] t = '0;
    logic [5:0]  oldp [32];
    logic [5:0]  e = {a[5], a[4:0]};
    if (a[9]) t = '1;
    else if (a[8]) begin
      if (a[7]) t[31:16] = d; else t[15:0] = d;
    end else t[d[4:0]] = 1'b1;
    for (int i = 0; i < 32; i++) oldp[i] = mp[i];
    for (int i = 0; i < 32; i++) begin
      if (fire && t[i]) mp[i] = e;
      if (fire && (a[9] || tm) && t[i]) ma[i] = e;
      else if (cm) ma[i] = oldp[i];
    end
  endfunction

  task automatic check(string tag);
    item_t it;
    it.tag = tag;
    it.d = 32'hA5C3_19F0; it.a = 1'b0; it.exp = model_out(it.d, it.a); q.push_back(it);
    it.d = 32'h5A3C_E60F; it.a = 1'b1; it.exp = model_out(it.d, it.a); q.push_back(it);
    it.d = 32'h1248_8421; it.a = 1'b1; it.exp = model_out(it.d, it.a); q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic step(bit cs_n, bit ld_n, logic [9:0] a, logic [15:0] d, bit cm_n);
    @(negedge clk);
    sel_n = cs_n; wr_n = ld_n; addr = a; wdata = d; commit_n = cm_n;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; commit_n = 1'b1;
    model_step(!cs_n && !ld_n, a, d, !cm_n);
  endtask

  task automatic set_transp(bit v);
    @(negedge clk);
    transp = v;
    @(negedge clk);
    tm = v;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (q.size() != 0);
      it = q[0];
      din = it.d; adv_in = it.a;
      #1;
      n_tests++;
      if (dout !== it.exp) begin
        n_fail++;
        $display("FAIL %s dout=%h expected=%h", it.tag, dout, it.exp);
      end
      void'(q.pop_front());
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 32; i++) begin mp[i] = 6'(i); ma[i] = 6'(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 R2 reset identity");

    step(0, 0, 10'd7, 16'd3, 1);
    check("R3 unicast staged only");
    step(1, 1, 10'd0, 16'd0, 0);
    check("R7 commit moves staging");

    step(1, 0, 10'd12, 16'd4, 1);
    step(0, 1, 10'd13, 16'd5, 1);
    step(1, 1, 10'd0, 16'd0, 0);
    check("R8 no write without select and strobe");

    step(0, 0, 10'h100 | 10'd20, 16'h00F0, 1);
    check("R4 multicast lower staged only");
    step(1, 1, 10'd0, 16'd0, 0);
    check("R4 multicast lower committed");

    step(0, 0, 10'h100 | 10'h080 | 10'h020 | 10'd9, 16'h8001, 1);
    step(1, 1, 10'd0, 16'd0, 0);
    check("R4 R6 multicast upper advertise");

    step(0, 0, 10'h200 | 10'd11, 16'h0000, 1);
    check("R5 broadcast without commit");
    step(0, 0, 10'h3FF & (10'h200 | 10'h020 | 10'd3), 16'h0000, 1);
    check("R5 R6 broadcast advertise ignores index");
    step(0, 0, 10'h200 | 10'd0, 16'd0, 1);
    check("R5 broadcast input 0");

    step(0, 0, 10'd1, 16'd5, 1);
    check("R3 staging out5 before transparent");
    set_transp(1'b1);
    step(0, 0, 10'd2, 16'd9, 1);
    check("R9 transparent unicast immediate");
    step(0, 0, 10'h100 | 10'd25, 16'h0300, 1);
    check("R9 transparent multicast immediate");
    step(0, 0, 10'd30, 16'd6, 0);
    check("R10 transparent write with commit");
    set_transp(1'b0);
    step(0, 0, 10'd17, 16'd31, 1);
    check("R9 transparent off stages only");
    step(0, 0, 10'h200 | 10'd4, 16'd0, 0);
    check("R10 broadcast with commit");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule